// File: doc/BRIEF.md
# Iterative Multiply and Divide Unit

This block is the multiply/divide engine for a 16-bit datapath. It takes an operation code, a 32-bit operand A and a 16-bit operand B, and produces a 32-bit result, a 16-bit remainder, an overflow flag and a divide-by-zero flag. Each operation finishes with a one-cycle `res_done` pulse. It handles byte and word multiplies, signed and unsigned. It also handles word integer division, unsigned fractional division, and division of a 32-bit dividend by a 16-bit divisor, in signed and unsigned forms.

The work is done one bit per clock. Multiplies use a shift-and-add loop. Divides use a radix-2 restoring loop that always produces 16 quotient bits. Signed operations run on magnitudes, and the signs are applied in a final cycle. Divide-by-zero, and quotient overflow that can be seen from the operands alone, skip the loop.

Operands enter through a valid/ready handshake. `in_ready` is high only while the unit is idle. An operation is taken on a rising edge where `in_valid` and `in_ready` are both high. While the unit is busy, `in_valid` is ignored, so a requester must hold its operands until it sees `in_ready`. The result side has no back-pressure. The result registers hold their values until the next completion, and `res_done` marks the cycle in which new values appear.

Top module: `muldiv_unit`

## Requirements
- R1: Op code 0 multiplies `in_a[7:0]` by `in_b[7:0]` unsigned, and op code 1 does the same in two's complement. The 16-bit product goes to `res_data[15:0]` and `res_data[31:16]` is zero. Higher operand bits have no effect.
- R2: Op code 2 multiplies `in_a[15:0]` by `in_b` unsigned, and op code 3 multiplies them signed. Both give a full 32-bit product on `res_data`.
- R3: Op code 4 (unsigned) and op code 5 (signed) divide `in_a[15:0]` by `in_b`. The quotient goes to `res_data[15:0]`, with the upper half zero, and the remainder goes to `res_rem`. Signed quotients truncate toward zero, and a nonzero signed remainder carries the sign of the dividend.
- R4: Op code 6 returns floor(`in_a[15:0]` × 65536 / `in_b`) as quotient and the leftover as remainder. When `in_b` is nonzero and not greater than `in_a[15:0]`, the operation is flagged as overflow instead.
- R5: Op code 7 (unsigned) and op code 8 (signed) divide the 32-bit `in_a` by `in_b`. They follow the rounding and sign rules of R3. A quotient outside 0..65535 (unsigned) or −32768..32767 (signed) is flagged as overflow.
- R6: Any divide (op codes 4 to 8) with `in_b` = 0 sets `res_dz`=1 and `res_ovf`=0. `res_data` becomes 0x0000FFFF and `res_rem` keeps its previous value.
- R7: An overflowing divide, including signed 16-bit −32768 / −1, sets `res_ovf`=1 and `res_dz`=0. It leaves `res_data` and `res_rem` unchanged.
- R8: `in_ready` is high exactly when idle, including the cycle in which `res_done` is high. `in_valid` presented while busy is ignored and causes no later completion.
- R9: `res_done` is high for one cycle only. Counting from the accepting edge, it rises 9 edges later for op codes 0–1, 17 edges later for multiplies and non-overflowing divides otherwise, and 1 edge later for division by zero or operand-visible overflow (R4, R7, unsigned R5).
- R10: Reset clears `res_data`, `res_rem` and both flags. Outputs change only on the edge that raises `res_done` and hold otherwise. A completion without a fault clears both flags. Multiplies leave `res_rem` unchanged.
- R11: Op codes 9 to 15 behave exactly as op code 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation request valid |
| in_ready | output | 1 | Unit idle, request will be taken |
| in_op | input | 4 | Operation code (see R1–R5, R11) |
| in_a | input | 32 | Operand A / dividend |
| in_b | input | 16 | Operand B / divisor |
| res_data | output | 32 | Product, or quotient in bits 15:0 |
| res_rem | output | 16 | Remainder of the last divide |
| res_ovf | output | 1 | Quotient overflow of the last operation |
| res_dz | output | 1 | Divide by zero in the last operation |
| res_done | output | 1 | One-cycle completion pulse |

## Verification
Two events can fall in the same cycle: the completion pulse of one operation and the acceptance of the next. This happens because `in_ready` is already high while `res_done` is high. The bench provokes it by raising `in_valid` with a new request during the done cycle. It judges that the first result was visible and correct in that cycle, and that it stays on the outputs while the second operation runs. It then checks that the second operation finishes with the full latency and its own correct quotient and remainder.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  typedef enum logic [3:0] {
    OP_MULU8  = 4'd0,
    OP_MULS8  = 4'd1,
    OP_MULU16 = 4'd2,
    OP_MULS16 = 4'd3,
    OP_DIVU   = 4'd4,
    OP_DIVS   = 4'd5,
    OP_FDIV   = 4'd6,
    OP_EDIVU  = 4'd7,
    OP_EDIVS  = 4'd8
  } mdu_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } mdu_state_e;

  // Per-operation control decoded at acceptance
  typedef struct packed {
    logic mul;        // multiply path (else divide)
    logic half;       // byte-wide multiply
    logic sdiv;       // signed divide: quotient range check applies
    logic neg_q;      // negate product / quotient
    logic neg_r;      // negate remainder
    logic dz;         // divisor is zero
    logic early_ovf;  // overflow visible from operands
  } mdu_ctl_t;

endpackage

// File: rtl/mdu_prep.sv
module mdu_prep
  import mdu_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [3:0]      op,
  input  logic [2*DW-1:0] a,
  input  logic [DW-1:0]   b,
  output mdu_ctl_t        ctl,
  output logic [DW-1:0]   mul_x,
  output logic [DW-1:0]   mul_y,
  output logic [DW-1:0]   div_hi,
  output logic [DW-1:0]   div_lo,
  output logic [DW-1:0]   div_d
);
  localparam int HW = DW / 2;
  localparam int AW = 2 * DW;

  logic [HW-1:0] a_h, b_h, a_hm, b_hm;
  logic [DW-1:0] a_w, a_wm, b_wm;
  logic [AW-1:0] a_xm;
  logic          sa_h, sb_h, sa_w, sb_w, sa_x;

  assign a_h  = a[HW-1:0];
  assign b_h  = b[HW-1:0];
  assign a_w  = a[DW-1:0];
  assign sa_h = a_h[HW-1];
  assign sb_h = b_h[HW-1];
  assign sa_w = a_w[DW-1];
  assign sb_w = b[DW-1];
  assign sa_x = a[AW-1];

  // Two's complement magnitudes; the most negative value maps to 2^(n-1)
  assign a_hm = sa_h ? (~a_h + 1'b1) : a_h;
  assign b_hm = sb_h ? (~b_h + 1'b1) : b_h;
  assign a_wm = sa_w ? (~a_w + 1'b1) : a_w;
  assign b_wm = sb_w ? (~b + 1'b1) : b;
  assign a_xm = sa_x ? (~a + 1'b1) : a;

  always_comb begin
    ctl    = '0;
    mul_x  = a_w;
    mul_y  = b;
    div_hi = '0;
    div_lo = a_w;
    div_d  = b;
    case (op)
      OP_MULU8: begin
        ctl.mul  = 1'b1;
        ctl.half = 1'b1;
        mul_x    = {{(DW-HW){1'b0}}, a_h};
        mul_y    = {{(DW-HW){1'b0}}, b_h};
      end
      OP_MULS8: begin
        ctl.mul   = 1'b1;
        ctl.half  = 1'b1;
        ctl.neg_q = sa_h ^ sb_h;
        mul_x     = {{(DW-HW){1'b0}}, a_hm};
        mul_y     = {{(DW-HW){1'b0}}, b_hm};
      end
      OP_MULS16: begin
        ctl.mul   = 1'b1;
        ctl.neg_q = sa_w ^ sb_w;
        mul_x     = a_wm;
        mul_y     = b_wm;
      end
      OP_DIVU: begin
        div_hi = '0;
        div_lo = a_w;
      end
      OP_DIVS: begin
        ctl.sdiv  = 1'b1;
        ctl.neg_q = sa_w ^ sb_w;
        ctl.neg_r = sa_w;
        div_lo    = a_wm;
        div_d     = b_wm;
      end
      OP_FDIV: begin
        div_hi        = a_w;
        div_lo        = '0;
        ctl.early_ovf = (b <= a_w);
      end
      OP_EDIVU: begin
        div_hi        = a[AW-1:DW];
        div_lo        = a_w;
        ctl.early_ovf = (a[AW-1:DW] >= b);
      end
      OP_EDIVS: begin
        ctl.sdiv      = 1'b1;
        ctl.neg_q     = sa_x ^ sb_w;
        ctl.neg_r     = sa_x;
        div_hi        = a_xm[AW-1:DW];
        div_lo        = a_xm[DW-1:0];
        div_d         = b_wm;
        ctl.early_ovf = (a_xm[AW-1:DW] >= b_wm);
      end
      default: begin
        // op 2 and all unassigned codes: unsigned word multiply
        ctl.mul = 1'b1;
      end
    endcase
    if (!ctl.mul && (b == '0)) begin
      ctl.dz        = 1'b1;
      ctl.early_ovf = 1'b0;
    end
  end

endmodule

// File: rtl/mdu_mul_core.sv
module mdu_mul_core #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic [2*W-1:0] prod
);
  logic [2*W-1:0] acc, mc;
  logic [W-1:0]   mp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      mc  <= '0;
      mp  <= '0;
    end else if (load) begin
      acc <= '0;
      mc  <= {{W{1'b0}}, mcand};
      mp  <= mplier;
    end else if (step) begin
      if (mp[0]) acc <= acc + mc;
      mc <= {mc[2*W-2:0], 1'b0};
      mp <= {1'b0, mp[W-1:1]};
    end
  end

  assign prod = acc;

endmodule

// File: rtl/mdu_div_core.sv
module mdu_div_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] hi,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] dvsr,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  logic [W-1:0] rr, qq, dd;
  logic [W:0]   trial;
  logic         fits;

  // Partial remainder shifted left with the next dividend bit
  assign trial = {rr, qq[W-1]};
  assign fits  = (trial >= {1'b0, dd});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr <= '0;
      qq <= '0;
      dd <= '0;
    end else if (load) begin
      rr <= hi;
      qq <= lo;
      dd <= dvsr;
    end else if (step) begin
      rr <= fits ? (trial[W-1:0] - dd) : trial[W-1:0];
      qq <= {qq[W-2:0], fits};
    end
  end

  assign quo = qq;
  assign rem = rr;

endmodule

// File: rtl/mdu_finish.sv
module mdu_finish
  import mdu_pkg::*;
#(
  parameter int DW = 16
) (
  input  mdu_ctl_t        ctl,
  input  logic [2*DW-1:0] prod,
  input  logic [DW-1:0]   quo,
  input  logic [DW-1:0]   rem,
  output logic [2*DW-1:0] res_val,
  output logic [DW-1:0]   rem_val,
  output logic            late_ovf
);
  localparam int AW = 2 * DW;
  localparam logic [DW-1:0] MIN_MAG = {1'b1, {(DW-1){1'b0}}};

  logic [DW-1:0] p_half, q_fix;

  always_comb begin
    p_half   = ctl.neg_q ? (~prod[DW-1:0] + 1'b1) : prod[DW-1:0];
    q_fix    = ctl.neg_q ? (~quo + 1'b1) : quo;
    rem_val  = ctl.neg_r ? (~rem + 1'b1) : rem;
    late_ovf = 1'b0;
    if (ctl.mul) begin
      if (ctl.half) res_val = {{DW{1'b0}}, p_half};
      else          res_val = ctl.neg_q ? (~prod + 1'b1) : prod;
    end else begin
      res_val = {{(AW-DW){1'b0}}, q_fix};
      // Signed quotient must land in the signed range of DW bits
      if (ctl.sdiv) late_ovf = ctl.neg_q ? (quo > MIN_MAG) : quo[DW-1];
    end
  end

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import mdu_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [3:0]      in_op,
  input  logic [2*DW-1:0] in_a,
  input  logic [DW-1:0]   in_b,
  output logic [2*DW-1:0] res_data,
  output logic [DW-1:0]   res_rem,
  output logic            res_ovf,
  output logic            res_dz,
  output logic            res_done
);
  localparam int HW = DW / 2;
  localparam int AW = 2 * DW;
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST_HALF = CW'(HW - 1);
  localparam logic [CW-1:0] LAST_FULL = CW'(DW - 1);

  mdu_state_e    state;
  logic [CW-1:0] cnt;
  mdu_ctl_t      ctl_d, ctl_q;
  logic          accept, run_mul, run_div, late_ovf;
  logic [DW-1:0] mul_x, mul_y, div_hi, div_lo, div_d, quo, rem, rem_val;
  logic [AW-1:0] prod, res_val;

  assign in_ready = (state == ST_IDLE);
  assign accept   = in_valid && in_ready;
  assign run_mul  = (state == ST_RUN) && ctl_q.mul;
  assign run_div  = (state == ST_RUN) && !ctl_q.mul;

  mdu_prep #(.DW(DW)) u_prep (
    .op(in_op), .a(in_a), .b(in_b), .ctl(ctl_d),
    .mul_x(mul_x), .mul_y(mul_y),
    .div_hi(div_hi), .div_lo(div_lo), .div_d(div_d)
  );

  mdu_mul_core #(.W(DW)) u_mul (
    .clk(clk), .rst_n(rst_n), .load(accept), .step(run_mul),
    .mcand(mul_x), .mplier(mul_y), .prod(prod)
  );

  mdu_div_core #(.W(DW)) u_div (
    .clk(clk), .rst_n(rst_n), .load(accept), .step(run_div),
    .hi(div_hi), .lo(div_lo), .dvsr(div_d), .quo(quo), .rem(rem)
  );

  mdu_finish #(.DW(DW)) u_fin (
    .ctl(ctl_q), .prod(prod), .quo(quo), .rem(rem),
    .res_val(res_val), .rem_val(rem_val), .late_ovf(late_ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      ctl_q    <= '0;
      res_data <= '0;
      res_rem  <= '0;
      res_ovf  <= 1'b0;
      res_dz   <= 1'b0;
      res_done <= 1'b0;
    end else begin
      res_done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            ctl_q <= ctl_d;
            cnt   <= ctl_d.half ? LAST_HALF : LAST_FULL;
            state <= (ctl_d.dz || ctl_d.early_ovf) ? ST_FIN : ST_RUN;
          end
        end
        ST_RUN: begin
          if (cnt == '0) state <= ST_FIN;
          else           cnt   <= cnt - 1'b1;
        end
        ST_FIN: begin
          state    <= ST_IDLE;
          res_done <= 1'b1;
          if (ctl_q.dz) begin
            res_data <= {{DW{1'b0}}, {DW{1'b1}}};
            res_dz   <= 1'b1;
            res_ovf  <= 1'b0;
          end else if (ctl_q.early_ovf || late_ovf) begin
            res_ovf  <= 1'b1;
            res_dz   <= 1'b0;
          end else begin
            res_data <= res_val;
            if (!ctl_q.mul) res_rem <= rem_val;
            res_ovf  <= 1'b0;
            res_dz   <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mdu_chk.sv
module mdu_chk #(
  parameter int DW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [2*DW-1:0] res_data,
  input logic [DW-1:0]   res_rem,
  input logic            res_ovf,
  input logic            res_dz,
  input logic            res_done
);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |=> !res_done);

  // R9
  accept_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !res_done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |-> in_ready);

  // R7
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_ovf && res_dz));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_done |-> ($stable(res_data) && $stable(res_rem) &&
                   $stable(res_ovf) && $stable(res_dz)));

  // R6
  dz_rem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_done && res_dz) |-> $stable(res_rem));

endmodule

bind muldiv_unit mdu_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .res_data(res_data), .res_rem(res_rem), .res_ovf(res_ovf),
  .res_dz(res_dz), .res_done(res_done)
);

// File: tb/muldiv_unit_test.sv
module muldiv_unit_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [3:0]  in_op;
  logic [31:0] in_a;
  logic [15:0] in_b;
  logic [31:0] res_data;
  logic [15:0] res_rem;
  logic        res_ovf, res_dz, res_done;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  always #4 clk = ~clk;

  muldiv_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .res_data(res_data),
    .res_rem(res_rem), .res_ovf(res_ovf), .res_dz(res_dz), .res_done(res_done)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] a;
    logic [15:0] b;
    logic [31:0] q;
    logic [15:0] r;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    {4'd0, 32'h0000_12FF, 16'h34FF, 32'h0000_FE01, 16'h0000},
    {4'd1, 32'h0000_00FF, 16'h0080, 32'h0000_0080, 16'h0000},
    {4'd1, 32'h0000_007F, 16'h0080, 32'h0000_C080, 16'h0000},
    {4'd2, 32'h0000_FFFF, 16'hFFFF, 32'hFFFE_0001, 16'h0000},
    {4'd3, 32'h0000_FFFF, 16'h8000, 32'h0000_8000, 16'h0000},
    {4'd3, 32'h0000_1234, 16'hFFFE, 32'hFFFF_DB98, 16'h0000},
    {4'd3, 32'h0000_8000, 16'h8000, 32'h4000_0000, 16'h0000},
    {4'd4, 32'h0000_1234, 16'h0010, 32'h0000_0123, 16'h0004},
    {4'd4, 32'h0000_FFFF, 16'hFFFF, 32'h0000_0001, 16'h0000},
    {4'd4, 32'h0000_0005, 16'h0007, 32'h0000_0000, 16'h0005},
    {4'd5, 32'h0000_FFF9, 16'h0002, 32'h0000_FFFD, 16'hFFFF},
    {4'd5, 32'h0000_0007, 16'hFFFE, 32'h0000_FFFD, 16'h0001},
    {4'd5, 32'h0000_FFF9, 16'hFFFE, 32'h0000_0003, 16'hFFFF},
    {4'd5, 32'h0000_8000, 16'h0001, 32'h0000_8000, 16'h0000},
    {4'd6, 32'h0000_0001, 16'h0002, 32'h0000_8000, 16'h0000},
    {4'd6, 32'h0000_0001, 16'h0003, 32'h0000_5555, 16'h0001},
    {4'd6, 32'h0000_7FFF, 16'hFFFF, 32'h0000_7FFF, 16'h7FFF},
    {4'd7, 32'h0001_0000, 16'h0002, 32'h0000_8000, 16'h0000},
    {4'd7, 32'hFFFE_FFFF, 16'hFFFF, 32'h0000_FFFF, 16'hFFFE},
    {4'd7, 32'h0012_3456, 16'h0100, 32'h0000_1234, 16'h0056},
    {4'd8, 32'hFFFE_7960, 16'h0007, 32'h0000_C833, 16'hFFFB},
    {4'd8, 32'h0001_86A0, 16'hFFF9, 32'h0000_C833, 16'h0005},
    {4'd8, 32'hFFFF_0000, 16'h0002, 32'h0000_8000, 16'h0000}
  };

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd0, 4'd1: return "R1";
      4'd2, 4'd3: return "R2";
      4'd4, 4'd5: return "R3";
      4'd6:       return "R4";
      4'd7, 4'd8: return "R5";
      default:    return "R11";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive a request; returns at the negedge after the accepting edge
  task automatic start_op(input logic [3:0] op, input logic [31:0] a, input logic [15:0] b);
    in_op    = op;
    in_a     = a;
    in_b     = b;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_done(output int lat);
    lat = 0;
    do begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end while (!res_done && lat < 100);
    if (!res_done) chk("R9 completion", 32'(lat), 32'd0);
  endtask

  task automatic run(input logic [3:0] op, input logic [31:0] a, input logic [15:0] b, output int lat);
    start_op(op, a, b);
    wait_done(lat);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    int lat;
    logic extra;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_op    = '0;
    in_a     = '0;
    in_b     = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state, R8 idle readiness
    chk("R10 reset data", res_data, 32'h0);
    chk("R10 reset rem", 32'(res_rem), 32'h0);
    chk("R10 reset flags", {30'h0, res_ovf, res_dz}, 32'h0);
    chk("R9 reset done", 32'(res_done), 32'h0);
    chk("R8 reset ready", 32'(in_ready), 32'h1);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      run(VEC[i].op, VEC[i].a, VEC[i].b, lat);
      chk(req_of(VEC[i].op), res_data, VEC[i].q);
      if (VEC[i].op >= 4'd4) chk(req_of(VEC[i].op), 32'(res_rem), 32'(VEC[i].r));
      chk("R10 flags clear", {30'h0, res_ovf, res_dz}, 32'h0);
      chk("R9 latency", 32'(lat), (VEC[i].op < 4'd2) ? 32'd9 : 32'd17);
    end

    // R6 divide by zero keeps remainder
    run(4'd4, 32'h1234, 16'h0010, lat);
    chk("R3 setup", 32'(res_rem), 32'h4);
    run(4'd5, 32'h00FF, 16'h0000, lat);
    chk("R6 dz data", res_data, 32'h0000_FFFF);
    chk("R6 dz rem", 32'(res_rem), 32'h4);
    chk("R6 dz flags", {30'h0, res_ovf, res_dz}, 32'h1);
    chk("R9 dz latency", 32'(lat), 32'd1);

    run(4'd4, 32'h1234, 16'h0010, lat);
    chk("R10 dz cleared", {30'h0, res_ovf, res_dz}, 32'h0);

    // R4 fractional overflow when divisor <= dividend
    run(4'd6, 32'h5, 16'h5, lat);
    chk("R4 ovf flags", {30'h0, res_ovf, res_dz}, 32'h2);
    chk("R7 ovf data held", res_data, 32'h0000_0123);
    chk("R7 ovf rem held", 32'(res_rem), 32'h4);
    chk("R9 early ovf latency", 32'(lat), 32'd1);

    // R5 extended unsigned overflow
    run(4'd7, 32'h1234_5678, 16'h1000, lat);
    chk("R5 unsigned ovf", {30'h0, res_ovf, res_dz}, 32'h2);
    chk("R5 data held", res_data, 32'h0000_0123);

    // R7 signed -32768 / -1
    run(4'd5, 32'h0000_8000, 16'hFFFF, lat);
    chk("R7 min/-1 ovf", {30'h0, res_ovf, res_dz}, 32'h2);
    chk("R7 min/-1 rem held", 32'(res_rem), 32'h4);
    chk("R9 late ovf latency", 32'(lat), 32'd17);

    // R5 signed range edges
    run(4'd8, 32'h0000_8000, 16'h0001, lat);
    chk("R5 +32768 ovf", {30'h0, res_ovf, res_dz}, 32'h2);
    run(4'd8, 32'hFFFF_8000, 16'h0001, lat);
    chk("R5 -32768 fits", res_data, 32'h0000_8000);
    chk("R5 -32768 flags", {30'h0, res_ovf, res_dz}, 32'h0);

    // R11 unassigned codes act as word unsigned multiply
    run(4'd9, 32'hABCD_0003, 16'h0005, lat);
    chk("R11 op9", res_data, 32'h0000_000F);
    run(4'd15, 32'h0000_0100, 16'h0100, lat);
    chk("R11 op15", res_data, 32'h0001_0000);
    chk("R11 latency", 32'(lat), 32'd17);

    // R8 request while busy is ignored
    start_op(4'd2, 32'h7, 16'h6);
    in_op    = 4'd4;
    in_a     = 32'h64;
    in_b     = 16'h0;
    in_valid = 1'b1;
    chk("R8 busy not ready", 32'(in_ready), 32'h0);
    repeat (5) @(negedge clk);
    in_valid = 1'b0;
    wait_done(lat);
    chk("R8 busy result", res_data, 32'd42);
    chk("R8 busy no dz", 32'(res_dz), 32'h0);
    extra = 1'b0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (res_done) extra = 1'b1;
    end
    chk("R8 no extra completion", 32'(extra), 32'h0);

    // Accept in the done cycle (back to back)
    run(4'd3, 32'h0000_FFFF, 16'h0003, lat);
    chk("R2 first of pair", res_data, 32'hFFFF_FFFD);
    chk("R8 ready in done cycle", 32'(in_ready), 32'h1);
    start_op(4'd4, 32'd100, 16'd7);
    chk("R10 held while next runs", res_data, 32'hFFFF_FFFD);
    chk("R8 busy after accept", 32'(in_ready), 32'h0);
    wait_done(lat);
    chk("R3 second of pair", res_data, 32'd14);
    chk("R3 second rem", 32'(res_rem), 32'd2);
    chk("R9 second latency", 32'(lat), 32'd17);

    // R10 hold after completion
    repeat (6) @(negedge clk);
    chk("R10 hold", res_data, 32'd14);

    summary();
    $finish;
  end

endmodule